// File: doc/BRIEF.md
# Tracking Converter Up/Down Controller

This block is the digital loop of a tracking analog-to-digital converter. It keeps an unsigned code that drives an external DAC. An external comparator reports each cycle whether the DAC voltage lies below the sampled input. On every enabled clock the code moves one LSB toward the input. There is no conversion request and no done strobe. The code is never cleared during operation, so the digital result is always the live count.

Once the loop has caught the input, the comparator flips on every cycle and the code dithers between two adjacent values. The block counts how many enabled cycles in a row have reversed direction. When that run reaches a threshold chosen at an input port, a lock flag is raised. When the enable is low, the whole loop stands still.

Top module: `trk_adc_ctrl`

## Requirements
- R1: On an enabled clock with `cmp_below_i` = 1 (DAC below input), the count rises by exactly one LSB, unless it already holds all-ones.
- R2: On an enabled clock with `cmp_below_i` = 0 (DAC at or above input), the count falls by exactly one LSB, unless it already holds zero.
- R3: The count saturates. It stays at all-ones when asked to rise there and at zero when asked to fall there. It never wraps.
- R4: Reset loads the count with mid-scale (only the MSB set), clears `locked_o` and forgets the direction history.
- R5: While `enable_i` is low, the count, `locked_o` and the direction history keep their values whatever `cmp_below_i` and `lock_cycles_i` do.
- R6: `dac_code_o` and `result_o` both always show the current count. No start input exists. A full-scale excursion from zero to all-ones completes in 2^W − 1 enabled clocks.
- R7: Each enabled clock whose direction differs from that of the previous enabled clock lengthens the reversal run by one, saturating at 2^LW − 1. A repeated direction resets the run to zero. The first enabled clock after reset starts the run at zero.
- R8: `locked_o` is registered. After each enabled clock it is high exactly when the reversal run is at least `lock_cycles_i`, with a threshold of 0 treated as 1. It therefore falls one clock after a repeated-direction step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Loop enable; low freezes all state |
| cmp_below_i | input | 1 | Comparator: 1 = DAC output below input voltage |
| lock_cycles_i | input | LW | Reversal run length needed for lock (0 acts as 1) |
| dac_code_o | output | W | Code to the external DAC |
| result_o | output | W | Digital conversion result (live count) |
| locked_o | output | 1 | Loop locked onto the input |

## Verification
Two functions can act in the same clock: a direction reversal that extends the lock run, and a saturated step in which the count cannot move. This happens when the count is pinned at a rail and the comparator flips back. The bench provokes it by placing the modelled input beyond each rail, then just inside it, across every pair of start and target codes. It checks that the count leaves the rail by one LSB while the run and lock flag follow the reversal rule. A second overlap is the enable dropping in the same clock as a direction change. The bench judges that case by checking the held count and lock flag on the following clocks.

// File: rtl/trk_pkg.sv
package trk_pkg;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

endpackage

// File: rtl/trk_step_unit.sv
module trk_step_unit #(
    parameter int W = 8
) (
    input  logic          en_i,
    input  trk_pkg::dir_e dir_i,
    input  logic [W-1:0]  cnt_i,
    output logic [W-1:0]  cnt_o
);
    localparam logic [W-1:0] CODE_TOP = '1;
    localparam logic [W-1:0] CODE_BOT = '0;

    always_comb begin
        cnt_o = cnt_i;
        if (en_i) begin
            if (dir_i == trk_pkg::DIR_UP) begin
                if (cnt_i != CODE_TOP) begin
                    cnt_o = cnt_i + W'(1);
                end
            end else begin
                if (cnt_i != CODE_BOT) begin
                    cnt_o = cnt_i - W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/trk_alt_tracker.sv
module trk_alt_tracker #(
    parameter int LW = 4
) (
    input  logic          en_i,
    input  trk_pkg::dir_e dir_i,
    input  trk_pkg::dir_e prev_dir_i,
    input  logic          hist_v_i,
    input  logic [LW-1:0] run_i,
    input  logic [LW-1:0] thr_i,
    input  logic          locked_i,
    output logic [LW-1:0] run_o,
    output logic          locked_o
);
    localparam logic [LW-1:0] RUN_MAX = '1;

    logic [LW-1:0] eff_thr;

    always_comb begin
        eff_thr  = (thr_i == '0) ? LW'(1) : thr_i;
        run_o    = run_i;
        locked_o = locked_i;
        if (en_i) begin
            if (hist_v_i && (dir_i != prev_dir_i)) begin
                if (run_i != RUN_MAX) begin
                    run_o = run_i + LW'(1);
                end
            end else begin
                run_o = '0;
            end
            locked_o = (run_o >= eff_thr);
        end
    end
endmodule

// File: rtl/trk_adc_ctrl.sv
module trk_adc_ctrl #(
    parameter int W  = 8,
    parameter int LW = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          enable_i,
    input  logic          cmp_below_i,
    input  logic [LW-1:0] lock_cycles_i,
    output logic [W-1:0]  dac_code_o,
    output logic [W-1:0]  result_o,
    output logic          locked_o
);
    localparam logic [W-1:0] CODE_MID = W'(1) << (W - 1);

    typedef struct packed {
        logic [W-1:0]  cnt;
        logic [LW-1:0] run;
        logic          hist_v;
        trk_pkg::dir_e prev;
        logic          locked;
    } state_t;

    state_t        st_d, st_q;
    trk_pkg::dir_e dir_now;
    logic [W-1:0]  cnt_nx;
    logic [LW-1:0] run_nx;
    logic          lock_nx;

    assign dir_now = cmp_below_i ? trk_pkg::DIR_UP : trk_pkg::DIR_DOWN;

    trk_step_unit #(.W(W)) u_step (
        .en_i  (enable_i),
        .dir_i (dir_now),
        .cnt_i (st_q.cnt),
        .cnt_o (cnt_nx)
    );

    trk_alt_tracker #(.LW(LW)) u_alt (
        .en_i       (enable_i),
        .dir_i      (dir_now),
        .prev_dir_i (st_q.prev),
        .hist_v_i   (st_q.hist_v),
        .run_i      (st_q.run),
        .thr_i      (lock_cycles_i),
        .locked_i   (st_q.locked),
        .run_o      (run_nx),
        .locked_o   (lock_nx)
    );

    always_comb begin
        st_d        = st_q;
        st_d.cnt    = cnt_nx;
        st_d.run    = run_nx;
        st_d.locked = lock_nx;
        if (enable_i) begin
            st_d.hist_v = 1'b1;
            st_d.prev   = dir_now;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt    <= CODE_MID;
            st_q.run    <= '0;
            st_q.hist_v <= 1'b0;
            st_q.prev   <= trk_pkg::DIR_DOWN;
            st_q.locked <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dac_code_o = st_q.cnt;
    assign result_o   = st_q.cnt;
    assign locked_o   = st_q.locked;
endmodule

// File: rtl/trk_adc_ctrl_chk.sv
module trk_adc_ctrl_chk #(
    parameter int W  = 8,
    parameter int LW = 4
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          enable_i,
    input logic          cmp_below_i,
    input logic [LW-1:0] lock_cycles_i,
    input logic [W-1:0]  dac_code_o,
    input logic [W-1:0]  result_o,
    input logic          locked_o
);
    localparam logic [W-1:0] CODE_TOP = '1;
    localparam logic [W-1:0] CODE_BOT = '0;

    // R1
    up_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && cmp_below_i && dac_code_o != CODE_TOP)
        |=> (dac_code_o == W'($past(dac_code_o) + W'(1))));

    // R2
    down_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && !cmp_below_i && dac_code_o != CODE_BOT)
        |=> (dac_code_o == W'($past(dac_code_o) - W'(1))));

    // R3
    top_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && cmp_below_i && dac_code_o == CODE_TOP)
        |=> (dac_code_o == CODE_TOP));

    // R3
    bot_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && !cmp_below_i && dac_code_o == CODE_BOT)
        |=> (dac_code_o == CODE_BOT));

    // R5
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> ($stable(dac_code_o) && $stable(locked_o)));

    // R8
    lock_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(locked_o) |-> $past(enable_i));

    // R8
    lock_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && $past(enable_i) && (cmp_below_i == $past(cmp_below_i)))
        |=> !locked_o);

    // R6
    result_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        result_o == dac_code_o);

    logic unused_ok;
    assign unused_ok = ^lock_cycles_i;
endmodule

bind trk_adc_ctrl trk_adc_ctrl_chk #(.W(W), .LW(LW)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .enable_i      (enable_i),
    .cmp_below_i   (cmp_below_i),
    .lock_cycles_i (lock_cycles_i),
    .dac_code_o    (dac_code_o),
    .result_o      (result_o),
    .locked_o      (locked_o)
);

// File: tb/trk_adc_ctrl_tb.sv
`timescale 1ns/1ps
module trk_adc_ctrl_tb;
    localparam int W    = 4;
    localparam int LW   = 3;
    localparam int MAXC = (1 << W) - 1;
    localparam int RMAX = (1 << LW) - 1;

    logic          clk = 1'b0;
    logic          rst_ni = 1'b0;
    logic          enable_i = 1'b0;
    logic          cmp_below_i = 1'b0;
    logic [LW-1:0] lock_cycles_i = '0;
    logic [W-1:0]  dac_code_o;
    logic [W-1:0]  result_o;
    logic          locked_o;

    int n_chk = 0;
    int n_fail = 0;
    int m_cnt, m_run, m_thr;
    bit m_hv, m_pd, m_lk;

    always #5 clk = ~clk;

    trk_adc_ctrl #(.W(W), .LW(LW)) u_dut (
        .clk_i(clk), .rst_ni(rst_ni), .enable_i(enable_i),
        .cmp_below_i(cmp_below_i), .lock_cycles_i(lock_cycles_i),
        .dac_code_o(dac_code_o), .result_o(result_o), .locked_o(locked_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "dac_code", int'(dac_code_o), m_cnt);
        chk("R6", "result", int'(result_o), m_cnt);
        chk(req, "locked", int'(locked_o), int'(m_lk));
    endtask

    task automatic model_reset();
        m_cnt = 1 << (W - 1);
        m_run = 0; m_hv = 0; m_pd = 0; m_lk = 0;
    endtask

    task automatic do_reset();
        rst_ni = 1'b0;
        enable_i = 1'b0;
        model_reset();
        @(negedge clk);
        @(negedge clk);
        check_all("R4");
        rst_ni = 1'b1;
        @(negedge clk);
    endtask

    // one clock: inputs driven at negedge, outputs checked at the next negedge
    task automatic step(input bit en, input bit cmp, input int thr, input string req);
        enable_i = en;
        cmp_below_i = cmp;
        lock_cycles_i = LW'(thr);
        @(posedge clk);
        if (en) begin
            if (cmp && m_cnt < MAXC) m_cnt++;
            else if (!cmp && m_cnt > 0) m_cnt--;
            if (m_hv && (cmp != m_pd)) begin
                if (m_run < RMAX) m_run++;
            end else begin
                m_run = 0;
            end
            m_hv = 1; m_pd = cmp;
            m_thr = (thr == 0) ? 1 : thr;
            m_lk = (m_run >= m_thr);
        end
        @(negedge clk);
        check_all(req);
    endtask

    // analog stand-in: input at (vin2/2) LSB, comparator says DAC below input
    task automatic track(input int vin2, input int cycles, input int thr, input string req);
        for (int i = 0; i < cycles; i++) begin
            step(1'b1, (2 * int'(dac_code_o)) < vin2, thr, req);
        end
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R6: full-scale climb from zero takes 2^W-1 enabled clocks
        track(-1, MAXC + 2, 3, "R3");
        chk("R3", "bottom rail", int'(dac_code_o), 0);
        track(2 * MAXC + 1, MAXC, 3, "R6");
        chk("R6", "full-scale in 2^W-1 clocks", int'(dac_code_o), MAXC);
        track(2 * MAXC + 1, 4, 3, "R3");
        chk("R3", "top rail", int'(dac_code_o), MAXC);

        // R1/R2/R7/R8: every start/target pair, rail overshoot and lock thresholds
        for (int s = -1; s <= MAXC; s++) begin
            for (int t = -1; t <= MAXC; t++) begin
                track(2 * s + 1, MAXC + 3, (s + t + 8) % 8, "R1");
                track(2 * t + 1, MAXC + 10, (t + 8) % 8, "R7");
                track(2 * t + 1, 3, (t + 3 + 8) % 8, "R8");
            end
        end

        // R8: repeated direction drops lock one clock later
        track(15, 12, 2, "R8");
        chk("R8", "locked before repeat", int'(locked_o), 1);
        step(1'b1, ~m_pd, 2, "R8");
        step(1'b1, m_pd, 2, "R8");
        chk("R8", "lock dropped", int'(locked_o), 0);

        // R5: enable low freezes everything, including over a direction change
        track(15, 12, 4, "R5");
        for (int i = 0; i < 12; i++) begin
            step(1'b0, (i % 3) == 0, i % 8, "R5");
        end
        step(1'b1, ~m_pd, 4, "R5");
        for (int i = 0; i < 6; i++) begin
            step(1'b0, 1'b1, 0, "R5");
        end
        track(15, 6, 0, "R7");

        // R2 pure descent, R1 pure ascent, R7 saturation of the run
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1, "R2");
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 1, "R1");
        for (int i = 0; i < 20; i++) step(1'b1, i[0], RMAX, "R7");

        // R4: reset in mid-run restores mid-scale and clears history
        do_reset();
        step(1'b1, 1'b0, 1, "R4");
        step(1'b1, 1'b1, 1, "R4");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule